// File: doc/BRIEF.md
# Key-Protected CPU Voltage-ID Controller

This block sits between a processor's voltage-ID pins and a core voltage regulator. It has three ways to produce the 6-bit code it sends to the regulator. It can pass the live input code straight through. It can drive a value that software has programmed. It can take a snapshot of the input code taken at a known moment, add a signed offset to it, and clamp the result. The output is registered, so it changes one clock after the condition that selects it.

Changes that could push the regulator away from the processor's own request are protected by a lock. Software must write four unlock bytes in order to a key register before two things take effect: the programmed value can reach the output, and the mode bits in the control register accept writes. A dedicated lock byte closes the lock again. Three events restore a safe state. Power-on, a system reset-out pulse and a CPU-slot change each take a fresh snapshot of the input code and drop the programmed-output enable. A slot change also clears the mode bits.

Register access uses a plain byte port: `idx`, `wdata`, a `wr_en` strobe, and a registered `rdata` that shows the register selected by `idx` one clock earlier.

Top module: `vid_guard`

## Requirements
- R1: After reset, and whenever neither the programmed value nor offset mode is selected, `vid_out` equals `vid_in` (masked per R10), registered one clock.
- R2: Writing 0x32, 0x5D, 0x42, 0xAC in that order to the key register (idx 0x03) sets key-OK. Writing 0x35 clears it. Key-OK reads as bit 0 of idx 0x03 and as bit 6 of idx 0x02.
- R3: A key byte that does not match the next expected byte restarts the sequence. If that byte is 0x32, it counts as the first byte of a new attempt.
- R4: The programmed value (idx 0x02 bits 5:0) drives `vid_out` only while the enable bit (idx 0x02 bit 7) is 1 and key-OK is 1.
- R5: In offset mode without wide offsets, `vid_out` is the latched code plus idx 0x01 bits 4:0 read as two's complement (-16..+15). Bit 5 of the offset is ignored.
- R6: With the wide-offset bit set, the full 6-bit offset is used as two's complement (-32..+31).
- R7: The offset sum saturates at 0 and at 63, or at 31 when 6-bit mode is off. It never wraps.
- R8: Reset, a `rst_out_evt` pulse and a `slot_evt` pulse each clear the programmed-output enable and re-latch `vid_in`. The latched code reads at idx 0x04.
- R9: The control register is idx 0x00, with bit 0 offset mode, bit 1 6-bit mode, bit 2 CPU select and bit 3 wide offset. Its reset value is 0x02. A `slot_evt` clears bits 0–2. Writes to it are ignored while key-OK is 0.
- R10: With 6-bit mode off, bit 5 of the input and latched codes is ignored and `vid_out[5]` is 0.
- R11: The programmed value takes priority over offset mode, and offset mode takes priority over bypass. The choice is re-evaluated every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| vid_in | input | VID_W | Voltage-ID code from the processor |
| wr_en | input | 1 | Register write strobe |
| idx | input | IDX_W | Register index for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the previous clock's `idx` |
| rst_out_evt | input | 1 | System reset-out pulse |
| slot_evt | input | 1 | CPU-slot change pulse |
| vid_out | output | VID_W | Voltage-ID code to the regulator |

## Verification
A stuck or mis-stepped unlock counter shows up as a key-OK status that disagrees with the byte history. It also shows as a programmed value that fails to appear on `vid_out` two clocks after the enabling write. An offset that is sign-extended from the wrong width, or a sum that wraps, changes `vid_out` one clock after the offset write, and the wrong value differs by 32 or 64. A missed re-latch or a mode bit that is not cleared is visible on the first `vid_out` after the event, and again when the latch and control registers are read back.

// File: rtl/vidg_pkg.sv
package vidg_pkg;
  localparam int BYTE_W   = 8;
  localparam int KEY_LEN  = 4;
  localparam int STEP_W   = $clog2(KEY_LEN);
  localparam logic [BYTE_W-1:0] LOCK_BYTE = 8'h35;

  localparam int REG_CTRL = 0;
  localparam int REG_OFS  = 1;
  localparam int REG_OUT  = 2;
  localparam int REG_KEY  = 3;
  localparam int REG_LAT  = 4;

  typedef struct packed {
    logic wide;
    logic cpu_sel;
    logic ext;
    logic otf;
  } ctrl_t;

  function automatic logic [BYTE_W-1:0] key_byte(input logic [STEP_W-1:0] i);
    case (i)
      2'd0:    key_byte = 8'h32;
      2'd1:    key_byte = 8'h5D;
      2'd2:    key_byte = 8'h42;
      default: key_byte = 8'hAC;
    endcase
  endfunction
endpackage

// File: rtl/vidg_unlock.sv
module vidg_unlock
  import vidg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [BYTE_W-1:0] key_data,
  output logic              key_ok
);
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      key_ok <= 1'b0;
    end else if (key_wr) begin
      if (key_data == LOCK_BYTE) begin
        step   <= '0;
        key_ok <= 1'b0;
      end else if (!key_ok) begin
        if (key_data == key_byte(step)) begin
          if (step == STEP_W'(KEY_LEN - 1)) begin
            step   <= '0;
            key_ok <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end else if (key_data == key_byte('0)) begin
          step <= STEP_W'(1);
        end else begin
          step <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/vidg_offset_calc.sv
module vidg_offset_calc #(
  parameter int VID_W = 6
) (
  input  logic [VID_W-1:0] base,
  input  logic [VID_W-1:0] ofs,
  input  logic             wide,
  input  logic             ext,
  output logic [VID_W-1:0] result
);
  localparam int SW = VID_W + 2;
  localparam int MAX_FULL   = (1 << VID_W) - 1;
  localparam int MAX_NARROW = (1 << (VID_W - 1)) - 1;

  logic signed [SW-1:0] ofs_s, sum, max_v;

  always_comb begin
    if (wide) ofs_s = SW'(signed'(ofs));
    else      ofs_s = SW'(signed'(ofs[VID_W-2:0]));
    sum   = signed'(SW'(base)) + ofs_s;
    max_v = ext ? SW'(MAX_FULL) : SW'(MAX_NARROW);
    if (sum < 0)          result = '0;
    else if (sum > max_v) result = max_v[VID_W-1:0];
    else                  result = sum[VID_W-1:0];
  end
endmodule

// File: rtl/vid_guard.sv
module vid_guard
  import vidg_pkg::*;
#(
  parameter int VID_W = 6,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VID_W-1:0]  vid_in,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              rst_out_evt,
  input  logic              slot_evt,
  output logic [VID_W-1:0]  vid_out
);
  localparam logic [VID_W-1:0] FULL_MASK   = '1;
  localparam logic [VID_W-1:0] NARROW_MASK = {1'b0, {(VID_W-1){1'b1}}};
  localparam ctrl_t CTRL_RST = '{wide: 1'b0, cpu_sel: 1'b0, ext: 1'b1, otf: 1'b0};

  ctrl_t            ctrl;
  logic [VID_W-1:0] offset, prog, latched, mask, ofs_val, next_out;
  logic             out_en, key_ok, relatch;
  logic             wr_ctrl, wr_ofs, wr_out, wr_key;

  assign wr_ctrl = wr_en && (idx == IDX_W'(REG_CTRL));
  assign wr_ofs  = wr_en && (idx == IDX_W'(REG_OFS));
  assign wr_out  = wr_en && (idx == IDX_W'(REG_OUT));
  assign wr_key  = wr_en && (idx == IDX_W'(REG_KEY));
  assign relatch = rst_out_evt || slot_evt;
  assign mask    = ctrl.ext ? FULL_MASK : NARROW_MASK;

  vidg_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_key),
    .key_data (wdata),
    .key_ok   (key_ok)
  );

  vidg_offset_calc #(.VID_W(VID_W)) u_calc (
    .base   (latched & mask),
    .ofs    (offset),
    .wide   (ctrl.wide),
    .ext    (ctrl.ext),
    .result (ofs_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= CTRL_RST;
      offset  <= '0;
      prog    <= '0;
      out_en  <= 1'b0;
      latched <= vid_in;
    end else begin
      if (wr_ctrl && key_ok) ctrl <= ctrl_t'(wdata[3:0]);
      if (wr_ofs) offset <= wdata[VID_W-1:0];
      if (wr_out) begin
        prog   <= wdata[VID_W-1:0];
        out_en <= wdata[BYTE_W-1];
      end
      if (relatch) begin
        latched <= vid_in;
        out_en  <= 1'b0;
      end
      if (slot_evt) begin
        ctrl.otf     <= 1'b0;
        ctrl.ext     <= 1'b0;
        ctrl.cpu_sel <= 1'b0;
      end
    end
  end

  always_comb begin
    if (key_ok && out_en) next_out = prog & mask;
    else if (ctrl.otf)    next_out = ofs_val;
    else                  next_out = vid_in & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) vid_out <= vid_in;
    else     vid_out <= next_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (idx)
        IDX_W'(REG_CTRL): rdata <= BYTE_W'(ctrl);
        IDX_W'(REG_OFS):  rdata <= BYTE_W'(offset);
        IDX_W'(REG_OUT):  rdata <= BYTE_W'({out_en, key_ok, prog});
        IDX_W'(REG_KEY):  rdata <= BYTE_W'(key_ok);
        IDX_W'(REG_LAT):  rdata <= BYTE_W'(latched);
        default:          rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vid_guard_chk.sv
module vid_guard_chk #(
  parameter int VID_W = 6,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [VID_W-1:0] vid_in,
  input logic [VID_W-1:0] vid_out,
  input logic [VID_W-1:0] prog,
  input logic             key_ok,
  input logic             out_en,
  input logic [3:0]       ctrl,
  input logic             wr_en,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       wdata,
  input logic             rst_out_evt,
  input logic             slot_evt
);
  logic             otf, ext;
  logic [VID_W-1:0] m;
  assign otf = ctrl[0];
  assign ext = ctrl[1];
  assign m   = ext ? {VID_W{1'b1}} : {1'b0, {(VID_W-1){1'b1}}};

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (!(key_ok && out_en) && !otf) |=> vid_out == $past(vid_in & m));

  // R2
  lock_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(3) && wdata == 8'h35) |=> !key_ok);

  // R4
  prog_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (key_ok && out_en) |=> vid_out == $past(prog & m));

  // R8
  event_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_out_evt || slot_evt) |=> !out_en);

  // R9
  slot_mode_chk: assert property (@(posedge clk) disable iff (rst)
    slot_evt |=> (ctrl[2:0] == 3'b000));

  // R9
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(0) && !key_ok && !slot_evt) |=> $stable(ctrl));

  // R10
  narrow_top_chk: assert property (@(posedge clk) disable iff (rst)
    !ext |=> !vid_out[VID_W-1]);
endmodule

bind vid_guard vid_guard_chk #(.VID_W(VID_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .vid_in      (vid_in),
  .vid_out     (vid_out),
  .prog        (prog),
  .key_ok      (key_ok),
  .out_en      (out_en),
  .ctrl        (ctrl),
  .wr_en       (wr_en),
  .idx         (idx),
  .wdata       (wdata),
  .rst_out_evt (rst_out_evt),
  .slot_evt    (slot_evt)
);

// File: tb/tb_vid_guard.sv
`timescale 1ns/1ps
module tb_vid_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] vid_in = 6'h2A;
  logic       wr_en = 1'b0;
  logic [7:0] idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rst_out_evt = 1'b0;
  logic       slot_evt = 1'b0;
  logic [5:0] vid_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vid_guard dut (
    .clk(clk), .rst(rst), .vid_in(vid_in), .wr_en(wr_en), .idx(idx),
    .wdata(wdata), .rdata(rdata), .rst_out_evt(rst_out_evt),
    .slot_evt(slot_evt), .vid_out(vid_out)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int i, input int d);
    @(negedge clk); idx = 8'(i); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int i, output int d);
    @(negedge clk); idx = 8'(i); wr_en = 1'b0;
    @(negedge clk); d = int'(rdata);
  endtask

  task automatic out_is(input string req, input int exp);
    repeat (2) @(negedge clk);
    chk(req, int'(vid_out), exp);
  endtask

  task automatic t_reset();
    int v;
    out_is("R1 reset bypass", 'h2A);
    rd(3, v); chk("R2 key locked at reset", v, 0);
    rd(0, v); chk("R9 ctrl reset", v, 'h02);
    rd(4, v); chk("R8 power-on latch", v, 'h2A);
  endtask

  task automatic t_bypass();
    vid_in = 6'h15;
    out_is("R1 bypass follows input", 'h15);
  endtask

  task automatic t_locked();
    int v;
    wr(2, 'h87);
    out_is("R4 locked programmed ignored", 'h15);
    wr(0, 'h01);
    rd(0, v); chk("R9 locked ctrl write ignored", v, 'h02);
    out_is("R9 locked otf not entered", 'h15);
  endtask

  task automatic t_unlock();
    int v;
    wr(3, 'h32); wr(3, 'h5D); wr(3, 'h11); wr(3, 'h42); wr(3, 'hAC);
    rd(3, v); chk("R3 broken sequence stays locked", v, 0);
    wr(3, 'h32); wr(3, 'h32); wr(3, 'h5D); wr(3, 'h42); wr(3, 'hAC);
    rd(3, v); chk("R3 R2 restart on first byte unlocks", v, 1);
    rd(2, v); chk("R2 key status in output reg", v, 'hC7);
    out_is("R4 programmed value drives", 'h07);
  endtask

  task automatic t_offset();
    wr(2, 'h00);
    wr(0, 'h03);
    wr(1, 'h05); out_is("R5 offset +5", 47);
    wr(1, 'h1E); out_is("R5 offset -2", 40);
    wr(1, 'h3E); out_is("R5 offset bit5 ignored", 40);
    wr(1, 'h10); out_is("R5 offset -16", 26);
  endtask

  task automatic t_wide();
    wr(0, 'h0B);
    wr(1, 'h20); out_is("R6 wide offset -32", 10);
    wr(1, 'h1F); out_is("R7 clamp high 63", 63);
  endtask

  task automatic t_narrow();
    wr(0, 'h09);
    wr(1, 'h1F); out_is("R7 R10 clamp high 31", 31);
    wr(1, 'h30); out_is("R7 clamp low 0", 0);
  endtask

  task automatic t_priority();
    int v;
    wr(0, 'h07);
    wr(1, 'h05); out_is("R11 offset over bypass", 47);
    wr(2, 'hBC); out_is("R11 programmed over offset", 'h3C);
    wr(3, 'h35);
    rd(3, v); chk("R2 lock byte clears key", v, 0);
    out_is("R11 falls back to offset after lock", 47);
  endtask

  task automatic t_rstout();
    int v;
    vid_in = 6'h11;
    @(negedge clk); rst_out_evt = 1'b1;
    @(negedge clk); rst_out_evt = 1'b0;
    out_is("R8 relatch after reset-out", 'h16);
    rd(2, v); chk("R8 enable cleared", v, 'h3C);
    rd(4, v); chk("R8 latch value", v, 'h11);
  endtask

  task automatic t_slot();
    int v;
    vid_in = 6'h3F;
    @(negedge clk); slot_evt = 1'b1;
    @(negedge clk); slot_evt = 1'b0;
    rd(0, v); chk("R9 slot clears mode bits", v, 'h00);
    out_is("R10 bypass drops bit5", 'h1F);
    rd(4, v); chk("R8 slot relatch", v, 'h3F);
    wr(0, 'h02);
    rd(0, v); chk("R9 locked ctrl write after slot", v, 'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bypass();
    t_locked();
    t_unlock();
    t_offset();
    t_wide();
    t_narrow();
    t_priority();
    t_rstout();
    t_slot();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule